// File: doc/BRIEF.md
# Scoreboard Issue Controller

This block is the central bookkeeping table of a dynamically scheduled pipeline that has a few functional units, by default four: an integer unit, an adder, a multiplier and a divider. Instructions arrive one at a time, already decoded. Each one carries an operation code, a destination register, two source registers and the index of the unit that must run it. The controller accepts an instruction only when that unit is idle and no instruction in flight already owns the destination register. It holds the instruction at its input with a stall until both conditions are met.

Each accepted instruction lives in its unit's table entry and moves through four phases: issue, operand read, execution and write-back. The controller grants the operand read only when no older instruction still has to produce either source. Operands always come from the register file, never from another unit. The unit then executes and signals completion with a one-cycle pulse. The controller grants write-back only when no older instruction still has an unread source that names the same register.

When write-back is granted, the controller drives the register-file write strobe and register number. It releases the destination's ownership and wakes every entry that was waiting on that producer. If several units are ready to write back, a fixed-priority choice lets one of them through per cycle.

Top module: `scoreboard_ctrl`

## Requirements
- R1: After reset, whether at power-up or in mid-run, every unit is idle and no register is owned. No grant or write strobe is active, and an instruction presented to any unit with any destination is not stalled.
- R2: An instruction is stalled while its target unit still holds an earlier instruction, in any phase up to and including the cycle of its write-back grant.
- R3: An instruction is stalled while an in-flight instruction owns its destination register. Once that owner's write-back grant cycle has passed, the same destination is accepted.
- R4: At most one instruction is accepted per cycle. An instruction presented with `iss_stall` low is accepted at that clock edge.
- R5: If neither source is owned by an in-flight producer, the unit's operand-read grant is high for exactly one cycle: the cycle after the acceptance edge. The unit then enters execution.
- R6: While a source is owned by an older producer, the read grant stays low. It rises in the cycle after that producer's write-back grant. If the producer is granted write-back in the same cycle as the consumer is accepted, that source counts as already available.
- R7: A completion pulse moves a unit from execution to write-back request; a pulse is ignored in any other phase. Without other conflicts, the write-back grant is high in the cycle after the edge that sampled the pulse.
- R8: A unit's write-back is withheld while another entry holds a source that is ready but not yet read and that equals its destination. The grant follows in the cycle after that read grant. A withheld unit does not block other units' write-backs.
- R9: When several units may write back in the same cycle, the one with the lowest index (bit 0 of `wb_grant`) is granted. The others wait for later cycles.
- R10: In the write-back grant cycle, `rf_wr_en` is high and `rf_wr_reg` carries the unit's destination. From the next cycle the unit is free and the register is unowned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| iss_valid | input | 1 | A decoded instruction is presented |
| iss_op | input | OP_W | Operation code |
| iss_dst | input | log2(NUM_REG) | Destination register |
| iss_src1 | input | log2(NUM_REG) | First source register |
| iss_src2 | input | log2(NUM_REG) | Second source register |
| iss_unit | input | log2(NUM_FU) | Functional unit index required |
| iss_stall | output | 1 | Instruction cannot be accepted this cycle |
| done_pulse | input | NUM_FU | Per-unit execution-complete pulse |
| rd_grant | output | NUM_FU | Per-unit operand-read grant |
| wb_grant | output | NUM_FU | Per-unit write-back grant |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_wr_reg | output | log2(NUM_REG) | Register-file write register number |
| ex_op | output | NUM_FU*OP_W | Operation code held by each unit's entry |

## Verification
All outputs are decoded from registered table state and the current inputs. A stall therefore applies in the same cycle the instruction is presented. A read grant is due in the cycle after the acceptance edge, or in the cycle after the producer's write-back grant. A write-back grant is due in the cycle after the edge that sampled the completion pulse, unless a pending reader or a lower-index unit defers it. The bench changes inputs on the falling edge and compares all outputs five nanoseconds before the next rising edge, with one expected row per cycle. Each expected row was derived by counting the single register stage between a cause and its effect.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_EXEC = 2'd2,
    ST_WB   = 2'd3
  } sb_stage_e;

endpackage

// File: rtl/sb_reg_status.sv
module sb_reg_status #(
  parameter int NUM_REG = 16,
  parameter int FUW     = 2,
  localparam int RW     = $clog2(NUM_REG)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          set_en,
  input  logic [RW-1:0]                 set_reg,
  input  logic [FUW-1:0]                set_unit,
  input  logic                          clr_en,
  input  logic [RW-1:0]                 clr_reg,
  output logic [NUM_REG-1:0]            pend,
  output logic [NUM_REG-1:0][FUW-1:0]   owner
);

  logic [NUM_REG-1:0]          own_v_q, own_v_d;
  logic [NUM_REG-1:0][FUW-1:0] own_u_q, own_u_d;

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    always_comb begin
      own_v_d[r] = own_v_q[r];
      own_u_d[r] = own_u_q[r];
      if (clr_en && (clr_reg == RW'(r))) own_v_d[r] = 1'b0;
      if (set_en && (set_reg == RW'(r))) begin
        own_v_d[r] = 1'b1;
        own_u_d[r] = set_unit;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        own_v_q[r] <= 1'b0;
        own_u_q[r] <= '0;
      end else begin
        own_v_q[r] <= own_v_d[r];
        if (set_en && (set_reg == RW'(r))) own_u_q[r] <= own_u_d[r];
      end
    end
  end

  assign pend  = own_v_q;
  assign owner = own_u_q;

  // R3: a register is never claimed while another writer still owns it
  p_single_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !own_v_q[set_reg]);

endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter #(
  parameter int NUM_FU = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_FU-1:0] req,
  output logic [NUM_FU-1:0] grant
);

  logic [NUM_FU:0] seen;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < NUM_FU; i++) begin : g_pri
    assign grant[i]    = req[i] & ~seen[i];
    assign seen[i + 1] = seen[i] | req[i];
  end

  // R9: at most one write-back per cycle, and only to a requester
  p_wb_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~req) == '0));

  // R9: any request yields a grant
  p_wb_progress_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> (grant != '0));

endmodule

// File: rtl/sb_fu_entry.sv
module sb_fu_entry
  import sb_pkg::*;
#(
  parameter int FUW  = 2,
  parameter int RW   = 4,
  parameter int OP_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_en,
  input  logic [OP_W-1:0] iss_op,
  input  logic [RW-1:0]   iss_dst,
  input  logic [RW-1:0]   iss_src1,
  input  logic [RW-1:0]   iss_src2,
  input  logic            src1_wait,
  input  logic [FUW-1:0]  src1_unit,
  input  logic            src2_wait,
  input  logic [FUW-1:0]  src2_unit,
  input  logic            done_pulse,
  input  logic            wb_any,
  input  logic [FUW-1:0]  wb_unit,
  input  logic            wb_self,
  output logic            busy,
  output logic [OP_W-1:0] op_o,
  output logic [RW-1:0]   fi_o,
  output logic [RW-1:0]   fj_o,
  output logic [RW-1:0]   fk_o,
  output logic            rj_o,
  output logic            rk_o,
  output logic            rd_req,
  output logic            wb_req
);

  sb_stage_e       stage_q, stage_d;
  logic [OP_W-1:0] op_q, op_d;
  logic [RW-1:0]   fi_q, fi_d, fj_q, fj_d, fk_q, fk_d;
  logic [FUW-1:0]  qj_q, qj_d, qk_q, qk_d;
  logic            qjv_q, qjv_d, qkv_q, qkv_d;
  logic            rj_q, rj_d, rk_q, rk_d;
  logic            load_en;

  assign rd_req  = (stage_q == ST_READ) && rj_q && rk_q;
  assign wb_req  = (stage_q == ST_WB);
  assign busy    = (stage_q != ST_IDLE);
  assign load_en = (stage_q == ST_IDLE) && issue_en;

  always_comb begin
    stage_d = stage_q;
    op_d    = op_q;
    fi_d    = fi_q;
    fj_d    = fj_q;
    fk_d    = fk_q;
    qj_d    = qj_q;
    qk_d    = qk_q;
    qjv_d   = qjv_q;
    qkv_d   = qkv_q;
    rj_d    = rj_q;
    rk_d    = rk_q;
    unique case (stage_q)
      ST_IDLE: begin
        if (issue_en) begin
          stage_d = ST_READ;
          op_d    = iss_op;
          fi_d    = iss_dst;
          fj_d    = iss_src1;
          fk_d    = iss_src2;
          qj_d    = src1_unit;
          qk_d    = src2_unit;
          qjv_d   = src1_wait;
          qkv_d   = src2_wait;
          rj_d    = !src1_wait;
          rk_d    = !src2_wait;
        end
      end
      ST_READ: begin
        if (wb_any && qjv_q && (qj_q == wb_unit)) begin
          qjv_d = 1'b0;
          rj_d  = 1'b1;
        end
        if (wb_any && qkv_q && (qk_q == wb_unit)) begin
          qkv_d = 1'b0;
          rk_d  = 1'b1;
        end
        if (rd_req) begin
          stage_d = ST_EXEC;
          rj_d    = 1'b0;
          rk_d    = 1'b0;
        end
      end
      ST_EXEC: begin
        if (done_pulse) stage_d = ST_WB;
      end
      ST_WB: begin
        if (wb_self) stage_d = ST_IDLE;
      end
      default: stage_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_IDLE;
      qjv_q   <= 1'b0;
      qkv_q   <= 1'b0;
      rj_q    <= 1'b0;
      rk_q    <= 1'b0;
    end else begin
      stage_q <= stage_d;
      qjv_q   <= qjv_d;
      qkv_q   <= qkv_d;
      rj_q    <= rj_d;
      rk_q    <= rk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= '0;
      fi_q <= '0;
      fj_q <= '0;
      fk_q <= '0;
      qj_q <= '0;
      qk_q <= '0;
    end else if (load_en) begin
      op_q <= op_d;
      fi_q <= fi_d;
      fj_q <= fj_d;
      fk_q <= fk_d;
      qj_q <= qj_d;
      qk_q <= qk_d;
    end
  end

  assign op_o = op_q;
  assign fi_o = fi_q;
  assign fj_o = fj_q;
  assign fk_o = fk_q;
  assign rj_o = rj_q;
  assign rk_o = rk_q;

  // R5: the read grant lasts one cycle and leads straight into execution
  p_read_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (stage_q == ST_EXEC) && !rd_req);

  // R7: a completion pulse outside execution never reaches write-back
  p_done_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == ST_READ) |=> (stage_q != ST_WB));

  // R6: no read while a producer is still outstanding
  p_wait_producer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((stage_q == ST_READ) && (qjv_q || qkv_q)) |-> !rd_req);

  // R10: a granted write-back frees the unit
  p_wb_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_self |=> !busy);

endmodule

// File: rtl/scoreboard_ctrl.sv
module scoreboard_ctrl #(
  parameter int NUM_FU  = 4,
  parameter int NUM_REG = 16,
  parameter int OP_W    = 4,
  localparam int FUW    = $clog2(NUM_FU),
  localparam int RW     = $clog2(NUM_REG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   iss_valid,
  input  logic [OP_W-1:0]        iss_op,
  input  logic [RW-1:0]          iss_dst,
  input  logic [RW-1:0]          iss_src1,
  input  logic [RW-1:0]          iss_src2,
  input  logic [FUW-1:0]         iss_unit,
  output logic                   iss_stall,
  input  logic [NUM_FU-1:0]      done_pulse,
  output logic [NUM_FU-1:0]      rd_grant,
  output logic [NUM_FU-1:0]      wb_grant,
  output logic                   rf_wr_en,
  output logic [RW-1:0]          rf_wr_reg,
  output logic [NUM_FU*OP_W-1:0] ex_op
);

  logic rst_s1_q, rst_s2_q, rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_n_int = rst_s2_q;

  logic [NUM_FU-1:0]           busy_v, rj_v, rk_v, rd_req_v, wb_req_v, war_ok;
  logic [NUM_FU-1:0][RW-1:0]   fi_a, fj_a, fk_a;
  logic [NUM_REG-1:0]          pend;
  logic [NUM_REG-1:0][FUW-1:0] owner;
  logic                        issue_ok, wb_fire;
  logic [FUW-1:0]              wb_unit;
  logic                        src1_wait, src2_wait;

  assign iss_stall = iss_valid && (busy_v[iss_unit] || pend[iss_dst]);
  assign issue_ok  = iss_valid && !iss_stall;
  assign wb_fire   = |wb_grant;

  always_comb begin
    wb_unit = '0;
    for (int i = 0; i < NUM_FU; i++) begin
      if (wb_grant[i]) wb_unit = FUW'(i);
    end
  end

  assign src1_wait = pend[iss_src1] && !(wb_fire && (owner[iss_src1] == wb_unit));
  assign src2_wait = pend[iss_src2] && !(wb_fire && (owner[iss_src2] == wb_unit));

  always_comb begin
    for (int f = 0; f < NUM_FU; f++) begin
      war_ok[f] = 1'b1;
      for (int g = 0; g < NUM_FU; g++) begin
        if ((g != f) && ((rj_v[g] && (fj_a[g] == fi_a[f])) ||
                         (rk_v[g] && (fk_a[g] == fi_a[f])))) begin
          war_ok[f] = 1'b0;
        end
      end
    end
  end

  for (genvar f = 0; f < NUM_FU; f++) begin : g_unit
    sb_fu_entry #(
      .FUW  (FUW),
      .RW   (RW),
      .OP_W (OP_W)
    ) i_entry (
      .clk        (clk),
      .rst_n      (rst_n_int),
      .issue_en   (issue_ok && (iss_unit == FUW'(f))),
      .iss_op     (iss_op),
      .iss_dst    (iss_dst),
      .iss_src1   (iss_src1),
      .iss_src2   (iss_src2),
      .src1_wait  (src1_wait),
      .src1_unit  (owner[iss_src1]),
      .src2_wait  (src2_wait),
      .src2_unit  (owner[iss_src2]),
      .done_pulse (done_pulse[f]),
      .wb_any     (wb_fire),
      .wb_unit    (wb_unit),
      .wb_self    (wb_grant[f]),
      .busy       (busy_v[f]),
      .op_o       (ex_op[f*OP_W +: OP_W]),
      .fi_o       (fi_a[f]),
      .fj_o       (fj_a[f]),
      .fk_o       (fk_a[f]),
      .rj_o       (rj_v[f]),
      .rk_o       (rk_v[f]),
      .rd_req     (rd_req_v[f]),
      .wb_req     (wb_req_v[f])
    );
  end

  assign rd_grant = rd_req_v;

  sb_wb_arbiter #(
    .NUM_FU (NUM_FU)
  ) i_arb (
    .clk   (clk),
    .rst_n (rst_n_int),
    .req   (wb_req_v & war_ok),
    .grant (wb_grant)
  );

  sb_reg_status #(
    .NUM_REG (NUM_REG),
    .FUW     (FUW)
  ) i_status (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .set_en   (issue_ok),
    .set_reg  (iss_dst),
    .set_unit (iss_unit),
    .clr_en   (wb_fire),
    .clr_reg  (rf_wr_reg),
    .pend     (pend),
    .owner    (owner)
  );

  assign rf_wr_en  = wb_fire;
  assign rf_wr_reg = fi_a[wb_unit];

  function automatic logic unread_match(input logic [RW-1:0] r);
    logic hit;
    hit = 1'b0;
    for (int g = 0; g < NUM_FU; g++) begin
      if (!wb_grant[g] && ((rj_v[g] && (fj_a[g] == r)) || (rk_v[g] && (fk_a[g] == r))))
        hit = 1'b1;
    end
    return hit;
  endfunction

  // R8: no register is written while an older reader still needs its old value
  p_war_respected_r8: assert property (@(posedge clk) disable iff (!rst_n_int)
    rf_wr_en |-> !unread_match(rf_wr_reg));

  // R10: the written register is owned by the unit doing the write
  p_rf_owner_r10: assert property (@(posedge clk) disable iff (!rst_n_int)
    rf_wr_en |-> (pend[rf_wr_reg] && (owner[rf_wr_reg] == wb_unit)));

  // R4: an accepted instruction occupies its unit at the next cycle
  p_issue_claims_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
    issue_ok |=> busy_v[$past(iss_unit)]);

endmodule

// File: tb/test_scoreboard_ctrl.sv
module test_scoreboard_ctrl;

  localparam int NUM_FU  = 4;
  localparam int NUM_REG = 16;
  localparam int OP_W    = 4;

  typedef struct packed {
    logic       v;
    logic [3:0] dst;
    logic [3:0] s1;
    logic [3:0] s2;
    logic [1:0] fu;
    logic [3:0] done;
    logic       stall;
    logic [3:0] rd;
    logic [3:0] wb;
    logic       rfen;
    logic [3:0] rfreg;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 29;

  // One row per clock cycle: inputs, then the outputs expected in that cycle.
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 4'd2,  4'd3,  4'd4,  2'd1, 4'b0000, 1'b0, 4'b0000, 4'b0000, 1'b0, 4'd0,  4'd4},  // R4 accept add
    '{1'b1, 4'd5,  4'd2,  4'd6,  2'd2, 4'b0000, 1'b0, 4'b0010, 4'b0000, 1'b0, 4'd0,  4'd5},  // R5 add reads
    '{1'b1, 4'd7,  4'd0,  4'd0,  2'd1, 4'b0100, 1'b1, 4'b0000, 4'b0000, 1'b0, 4'd0,  4'd2},  // R2 unit busy, R7 stray pulse
    '{1'b1, 4'd5,  4'd0,  4'd0,  2'd3, 4'b0010, 1'b1, 4'b0000, 4'b0000, 1'b0, 4'd0,  4'd3},  // R3 dst owned
    '{1'b0, 4'd0,  4'd0,  4'd0,  2'd0, 4'b0000, 1'b0, 4'b0000, 4'b0010, 1'b1, 4'd2,  4'd10}, // R10 write r2
    '{1'b1, 4'd6,  4'd1,  4'd1,  2'd0, 4'b0000, 1'b0, 4'b0100, 4'b0000, 1'b0, 4'd0,  4'd6},  // R6 mul wakes
    '{1'b0, 4'd0,  4'd0,  4'd0,  2'd0, 4'b0000, 1'b0, 4'b0001, 4'b0000, 1'b0, 4'd0,  4'd5},  // R5
    '{1'b0, 4'd0,  4'd0,  4'd0,  2'd0, 4'b0101, 1'b0, 4'b0000, 4'b0000, 1'b0, 4'd0,  4'd7},  // R7 two done
    '{1'b0, 4'd0,  4'd0,  4'd0,  2'd0, 4'b0000, 1'b0, 4'b0000, 4'b0001, 1'b1, 4'd6,  4'd9},  // R9 unit0 first
    '{1'b0, 4'd0,  4'd0,  4'd0,  2'd0, 4'b0000, 1'b0, 4'b0000, 4'b0100, 1'b1, 4'd5,  4'd9},  // R9 unit2 next
    '{1'b1, 4'd5,  4'd8,  4'd9,  2'd3, 4'b0000, 1'b0, 4'b0000, 4'b0000, 1'b0, 4'd0,  4'd3},  // R3 r5 freed
    '{1'b1, 4'd10, 4'd11, 4'd12, 2'd2, 4'b0000, 1'b0, 4'b1000, 4'b0000, 1'b0, 4'd0,  4'd5},  // R5
    '{1'b1, 4'd13, 4'd10, 4'd14, 2'd1, 4'b0000, 1'b0, 4'b0100, 4'b0000, 1'b0, 4'd0,  4'd6},  // R6 add waits r10
    '{1'b1, 4'd14, 4'd1,  4'd1,  2'd0, 4'b0000, 1'b0, 4'b0000, 4'b0000, 1'b0, 4'd0,  4'd6},  // R6 still held
    '{1'b0, 4'd0,  4'd0,  4'd0,  2'd0, 4'b0000, 1'b0, 4'b0001, 4'b0000, 1'b0, 4'd0,  4'd5},  // R5
    '{1'b0, 4'd0,  4'd0,  4'd0,  2'd0, 4'b0001, 1'b0, 4'b0000, 4'b0000, 1'b0, 4'd0,  4'd7},  // R7
    '{1'b0, 4'd0,  4'd0,  4'd0,  2'd0, 4'b0100, 1'b0, 4'b0000, 4'b0000, 1'b0, 4'd0,  4'd8},  // R8 unit0 held
    '{1'b0, 4'd0,  4'd0,  4'd0,  2'd0, 4'b0000, 1'b0, 4'b0000, 4'b0100, 1'b1, 4'd10, 4'd8},  // R8 bypass held
    '{1'b0, 4'd0,  4'd0,  4'd0,  2'd0, 4'b0000, 1'b0, 4'b0010, 4'b0000, 1'b0, 4'd0,  4'd8},  // R8 reader reads
    '{1'b0, 4'd0,  4'd0,  4'd0,  2'd0, 4'b0000, 1'b0, 4'b0000, 4'b0001, 1'b1, 4'd14, 4'd8},  // R8 released
    '{1'b0, 4'd0,  4'd0,  4'd0,  2'd0, 4'b1000, 1'b0, 4'b0000, 4'b0000, 1'b0, 4'd0,  4'd7},  // R7
    '{1'b0, 4'd0,  4'd0,  4'd0,  2'd0, 4'b0000, 1'b0, 4'b0000, 4'b1000, 1'b1, 4'd5,  4'd7},  // R7
    '{1'b0, 4'd0,  4'd0,  4'd0,  2'd0, 4'b0010, 1'b0, 4'b0000, 4'b0000, 1'b0, 4'd0,  4'd7},  // R7
    '{1'b0, 4'd0,  4'd0,  4'd0,  2'd0, 4'b0000, 1'b0, 4'b0000, 4'b0010, 1'b1, 4'd13, 4'd10}, // R10
    '{1'b1, 4'd3,  4'd1,  4'd2,  2'd0, 4'b0000, 1'b0, 4'b0000, 4'b0000, 1'b0, 4'd0,  4'd4},  // R4
    '{1'b0, 4'd0,  4'd0,  4'd0,  2'd0, 4'b0000, 1'b0, 4'b0001, 4'b0000, 1'b0, 4'd0,  4'd5},  // R5
    '{1'b0, 4'd0,  4'd0,  4'd0,  2'd0, 4'b0001, 1'b0, 4'b0000, 4'b0000, 1'b0, 4'd0,  4'd7},  // R7
    '{1'b1, 4'd4,  4'd3,  4'd3,  2'd1, 4'b0000, 1'b0, 4'b0000, 4'b0001, 1'b1, 4'd3,  4'd6},  // R6 same-cycle write
    '{1'b0, 4'd0,  4'd0,  4'd0,  2'd0, 4'b0000, 1'b0, 4'b0010, 4'b0000, 1'b0, 4'd0,  4'd6}   // R6 reads at once
  };

  logic                   clk;
  logic                   rst_n;
  logic                   iss_valid;
  logic [OP_W-1:0]        iss_op;
  logic [3:0]             iss_dst, iss_src1, iss_src2;
  logic [1:0]             iss_unit;
  logic                   iss_stall;
  logic [NUM_FU-1:0]      done_pulse, rd_grant, wb_grant;
  logic                   rf_wr_en;
  logic [3:0]             rf_wr_reg;
  logic [NUM_FU*OP_W-1:0] ex_op;

  int n_checks;
  int n_fails;
  bit finished;

  scoreboard_ctrl #(
    .NUM_FU  (NUM_FU),
    .NUM_REG (NUM_REG),
    .OP_W    (OP_W)
  ) i_scoreboard_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_valid  (iss_valid),
    .iss_op     (iss_op),
    .iss_dst    (iss_dst),
    .iss_src1   (iss_src1),
    .iss_src2   (iss_src2),
    .iss_unit   (iss_unit),
    .iss_stall  (iss_stall),
    .done_pulse (done_pulse),
    .rd_grant   (rd_grant),
    .wb_grant   (wb_grant),
    .rf_wr_en   (rf_wr_en),
    .rf_wr_reg  (rf_wr_reg),
    .ex_op      (ex_op)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic drive_idle();
    iss_valid  = 1'b0;
    iss_op     = '0;
    iss_dst    = '0;
    iss_src1   = '0;
    iss_src2   = '0;
    iss_unit   = '0;
    done_pulse = '0;
  endtask

  task automatic check_out(input string tag, input logic stall, input logic [3:0] rd,
                           input logic [3:0] wb, input logic rfen, input logic [3:0] rfreg);
    logic ok;
    n_checks++;
    ok = (iss_stall == stall) && (rd_grant == rd) && (wb_grant == wb) && (rf_wr_en == rfen) &&
         (!rfen || (rf_wr_reg == rfreg));
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: got stall=%b rd=%b wb=%b rf=%b/%0d, expected stall=%b rd=%b wb=%b rf=%b/%0d",
               tag, iss_stall, rd_grant, wb_grant, rf_wr_en, rf_wr_reg,
               stall, rd, wb, rfen, rfreg);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    drive_idle();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    n_checks = 0;
    n_fails  = 0;
    finished = 1'b0;
    rst_n    = 1'b0;
    drive_idle();
    repeat (3) @(negedge clk);
    // R1: during reset an instruction is not stalled and nothing is granted
    iss_valid = 1'b1;
    iss_unit  = 2'd2;
    iss_dst   = 4'd9;
    #5;
    check_out("R1 in reset", 1'b0, 4'b0000, 4'b0000, 1'b0, 4'd0);
    drive_idle();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #5;
    check_out("R1 after release", 1'b0, 4'b0000, 4'b0000, 1'b0, 4'd0);

    // Cycle-accurate table walk
    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      iss_valid  = VECS[k].v;
      iss_op     = OP_W'(k);
      iss_dst    = VECS[k].dst;
      iss_src1   = VECS[k].s1;
      iss_src2   = VECS[k].s2;
      iss_unit   = VECS[k].fu;
      done_pulse = VECS[k].done;
      #5;
      check_out($sformatf("R%0d vector %0d", VECS[k].req, k), VECS[k].stall, VECS[k].rd,
                VECS[k].wb, VECS[k].rfen, VECS[k].rfreg);
    end

    // Directed: mid-run reset frees a busy unit and an owned register (R1, R2)
    @(negedge clk);
    drive_idle();
    iss_valid = 1'b1;
    iss_unit  = 2'd2;
    iss_dst   = 4'd9;
    iss_src1  = 4'd9;
    iss_src2  = 4'd9;
    @(negedge clk);
    iss_unit = 2'd2;
    iss_dst  = 4'd11;
    #5;
    check_out("R2 unit held before reset", 1'b1, 4'b0100, 4'b0000, 1'b0, 4'd0);
    @(negedge clk);
    iss_unit = 2'd3;
    iss_dst  = 4'd9;
    #5;
    check_out("R3 owner held before reset", 1'b1, 4'b0000, 4'b0000, 1'b0, 4'd0);
    do_reset();
    iss_valid = 1'b1;
    iss_unit  = 2'd2;
    iss_dst   = 4'd9;
    #5;
    check_out("R1 mid-run reset cleared", 1'b0, 4'b0000, 4'b0000, 1'b0, 4'd0);
    @(negedge clk);
    drive_idle();
    #5;
    check_out("R5 read after reset", 1'b0, 4'b0100, 4'b0000, 1'b0, 4'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #2ms;
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule